// File: doc/BRIEF.md
# Arbitrated Dual-Port RAM

This block is a synchronous shared memory with two fully independent access ports, called left and right. Each port has a select, a read/write direction, an output enable, two byte-lane enables, an address, write data, read data with a valid flag, a busy output and a busy input. Either port can read or write any word in any cycle. Writes land at the clock edge. Read data is registered and appears one cycle after the request.

When both active ports point at the same word, the block decides which port goes ahead. A port that was already on that word in the previous cycle wins over one that has just arrived. If both arrive in the same cycle, the left port wins. The losing port's write is suppressed, and its busy output rises one cycle later. It stays high for as long as the clash lasts. Reads are never suppressed.

A mode strap lets several of these blocks be combined to build a wider word. In leader mode the block arbitrates and drives busy out. In follower mode it does no arbitration, keeps busy out low, and lets a high busy input veto that port's write. In this way every slice follows the one decision made by the leader slice.

The memory depth is a parameter. An address width of 13 gives 8K words. The default is smaller so that the default build stays light.

Top module: `shared_ram_arb`

## Requirements
- R1: After reset, both valid flags and both busy outputs are low.
- R2: The two ports can write different words in the same cycle, and each word then reads back what its own port wrote.
- R3: A port whose select is low, or whose two lane enables are both low, changes no memory word and returns valid low.
- R4: The upper lane enable controls data bits 15..8 and the lower lane enable controls bits 7..0, for both writes and reads. Only the enabled lanes are written. A lane that is not enabled reads back as zero.
- R5: Valid is high, with data, one cycle after a cycle in which select, read (rd=1), output enable and at least one lane enable were all high. Otherwise valid is low and the read data is zero.
- R6: In leader mode, if one port was already active on a word in the previous cycle and the other port now becomes active on the same word, the port that was there first wins. The newcomer's busy goes high one cycle later.
- R7: In leader mode, if both ports become active on the same word in the same cycle, the left port wins and the right port's busy goes high one cycle later.
- R8: The winner is held while both ports stay on the clashing word. The loser's busy falls one cycle after the addresses differ or the loser is deselected.
- R9: A losing write leaves memory unchanged. The winning write in the same cycle is applied.
- R10: In leader mode the busy inputs have no effect.
- R11: In follower mode both busy outputs stay low even when the addresses clash. A high busy input blocks that port's write and leaves its reads unaffected.
- R12: A read and a write to the same word in the same cycle (follower mode, no veto) return the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slave_mode | input | 1 | 0 = leader (arbitrates, drives busy), 1 = follower (obeys busy input) |
| l_sel | input | 1 | Left port select |
| l_rd | input | 1 | Left direction: 1 = read, 0 = write |
| l_oe | input | 1 | Left output enable |
| l_ub | input | 1 | Left upper lane enable (bits 15..8) |
| l_lb | input | 1 | Left lower lane enable (bits 7..0) |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_busy_in | input | 1 | Left write veto, used in follower mode |
| l_rdata | output | DATA_W | Left registered read data |
| l_rvalid | output | 1 | Left read data valid |
| l_busy_out | output | 1 | Left busy flag, set when the left port lost arbitration |
| r_sel | input | 1 | Right port select |
| r_rd | input | 1 | Right direction: 1 = read, 0 = write |
| r_oe | input | 1 | Right output enable |
| r_ub | input | 1 | Right upper lane enable (bits 15..8) |
| r_lb | input | 1 | Right lower lane enable (bits 7..0) |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_busy_in | input | 1 | Right write veto, used in follower mode |
| r_rdata | output | DATA_W | Right registered read data |
| r_rvalid | output | 1 | Right read data valid |
| r_busy_out | output | 1 | Right busy flag, set when the right port lost arbitration |

## Verification
The two functions that meet in one cycle are a write to a word and the other port's access to the same word. This clash is provoked by driving both ports onto one address at the same falling edge, or one cycle apart to test the earlier-arrival rule.

The outcome is judged in two ways. The loser's busy flag is sampled at the next falling edge. The word is then read back and compared with a reference array, which the bench updates only for writes that the requirements allow. A follower-mode pass repeats the clash with the veto inputs in charge and checks that the busy outputs stay low.

// File: rtl/sram_arb_pkg.sv
package sram_arb_pkg;
    typedef enum logic {
        WIN_LEFT  = 1'b0,
        WIN_RIGHT = 1'b1
    } win_e;
endpackage

// File: rtl/collision_arb.sv
module collision_arb
    import sram_arb_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic              l_act,
    input  logic              r_act,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              l_lose,
    output logic              r_lose,
    output logic              l_busy,
    output logic              r_busy
);
    typedef struct packed {
        logic              coll;
        win_e              win;
        logic              l_busy;
        logic              r_busy;
        logic              l_prev_act;
        logic              r_prev_act;
        logic [ADDR_W-1:0] l_prev_addr;
        logic [ADDR_W-1:0] r_prev_addr;
    } arb_st_t;

    arb_st_t st_d, st_q;
    logic    match, l_here, r_here, hold;
    win_e    win_now;

    always_comb begin
        match  = !slave_mode && l_act && r_act && (l_addr == r_addr);
        // a port was "here" if it was active on this word last cycle
        l_here = st_q.l_prev_act && (st_q.l_prev_addr == l_addr);
        r_here = st_q.r_prev_act && (st_q.r_prev_addr == r_addr);
        hold   = st_q.coll && l_here && r_here;
        if (hold)
            win_now = st_q.win;
        else if (r_here && !l_here)
            win_now = WIN_RIGHT;
        else
            win_now = WIN_LEFT;  // earlier left, or same-cycle tie
        l_lose = match && (win_now == WIN_RIGHT);
        r_lose = match && (win_now == WIN_LEFT);

        st_d             = st_q;
        st_d.coll        = match;
        st_d.win         = match ? win_now : WIN_LEFT;
        st_d.l_busy      = l_lose;
        st_d.r_busy      = r_lose;
        st_d.l_prev_act  = l_act;
        st_d.r_prev_act  = r_act;
        st_d.l_prev_addr = l_addr;
        st_d.r_prev_addr = r_addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign l_busy = st_q.l_busy;
    assign r_busy = st_q.r_busy;
endmodule

// File: rtl/port_ctrl.sv
module port_ctrl #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic              sel,
    input  logic              rd,
    input  logic              oe,
    input  logic              ub,
    input  logic              lb,
    input  logic              busy_in,
    input  logic              lose,
    input  logic [DATA_W-1:0] mem_q,
    output logic              act,
    output logic              wr_en,
    output logic [1:0]        lane_en,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    localparam int LANE_W = DATA_W / 2;

    typedef struct packed {
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } rd_st_t;

    rd_st_t            st_d, st_q;
    logic              blocked, rd_go;
    logic [DATA_W-1:0] mask;

    always_comb begin
        act     = sel && (ub || lb);
        lane_en = {ub, lb};
        blocked = slave_mode ? busy_in : lose;
        wr_en   = act && !rd && !blocked;
        rd_go   = act && rd && oe;
        mask    = {{LANE_W{ub}}, {LANE_W{lb}}};

        st_d.rvalid = rd_go;
        st_d.rdata  = rd_go ? (mem_q & mask) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata  = st_q.rdata;
    assign rvalid = st_q.rvalid;
endmodule

// File: rtl/dual_bank.sv
module dual_bank #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              l_we,
    input  logic [1:0]        l_lane,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic              r_we,
    input  logic [1:0]        r_lane,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] l_q,
    output logic [DATA_W-1:0] r_q
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LANE_W = DATA_W / 2;

    logic [DATA_W-1:0] mem [DEPTH];

    assign l_q = mem[l_addr];
    assign r_q = mem[r_addr];

    // right writes are applied after left ones on a shared lane
    always_ff @(posedge clk) begin
        for (int b = 0; b < 2; b++) begin
            if (l_we && l_lane[b])
                mem[l_addr][b*LANE_W +: LANE_W] <= l_wdata[b*LANE_W +: LANE_W];
            if (r_we && r_lane[b])
                mem[r_addr][b*LANE_W +: LANE_W] <= r_wdata[b*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/shared_ram_arb.sv
module shared_ram_arb #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic              l_sel,
    input  logic              l_rd,
    input  logic              l_oe,
    input  logic              l_ub,
    input  logic              l_lb,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic              l_busy_in,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_rvalid,
    output logic              l_busy_out,
    input  logic              r_sel,
    input  logic              r_rd,
    input  logic              r_oe,
    input  logic              r_ub,
    input  logic              r_lb,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    input  logic              r_busy_in,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_rvalid,
    output logic              r_busy_out
);
    logic              l_act, r_act, l_lose, r_lose, l_wr_en, r_wr_en;
    logic [1:0]        l_lane, r_lane;
    logic [DATA_W-1:0] l_q, r_q;

    collision_arb #(.ADDR_W(ADDR_W)) i_arb (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
        .l_act(l_act), .r_act(r_act), .l_addr(l_addr), .r_addr(r_addr),
        .l_lose(l_lose), .r_lose(r_lose),
        .l_busy(l_busy_out), .r_busy(r_busy_out)
    );

    port_ctrl #(.DATA_W(DATA_W)) i_left (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
        .sel(l_sel), .rd(l_rd), .oe(l_oe), .ub(l_ub), .lb(l_lb),
        .busy_in(l_busy_in), .lose(l_lose), .mem_q(l_q),
        .act(l_act), .wr_en(l_wr_en), .lane_en(l_lane),
        .rdata(l_rdata), .rvalid(l_rvalid)
    );

    port_ctrl #(.DATA_W(DATA_W)) i_right (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
        .sel(r_sel), .rd(r_rd), .oe(r_oe), .ub(r_ub), .lb(r_lb),
        .busy_in(r_busy_in), .lose(r_lose), .mem_q(r_q),
        .act(r_act), .wr_en(r_wr_en), .lane_en(r_lane),
        .rdata(r_rdata), .rvalid(r_rvalid)
    );

    dual_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_bank (
        .clk(clk),
        .l_we(l_wr_en), .l_lane(l_lane), .l_addr(l_addr), .l_wdata(l_wdata),
        .r_we(r_wr_en), .r_lane(r_lane), .r_addr(r_addr), .r_wdata(r_wdata),
        .l_q(l_q), .r_q(r_q)
    );
endmodule

// File: rtl/shared_ram_arb_chk.sv
module shared_ram_arb_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slave_mode,
    input logic              l_sel, l_rd, l_oe, l_ub, l_lb, l_busy_in,
    input logic              r_sel, r_rd, r_oe, r_ub, r_lb, r_busy_in,
    input logic [ADDR_W-1:0] l_addr,
    input logic [ADDR_W-1:0] r_addr,
    input logic              l_rvalid, r_rvalid,
    input logic              l_busy_out, r_busy_out,
    input logic              l_wr_en, r_wr_en
);
    logic l_a, r_a, clash;
    assign l_a   = l_sel && (l_ub || l_lb);
    assign r_a   = r_sel && (r_ub || r_lb);
    assign clash = l_a && r_a && (l_addr == r_addr) && !slave_mode;

    // R5: valid only after a full read request
    a_r5_l_valid_src: assert property (@(posedge clk) disable iff (!rst_n)
        l_rvalid |-> $past(l_a && l_rd && l_oe));
    a_r5_r_valid_src: assert property (@(posedge clk) disable iff (!rst_n)
        r_rvalid |-> $past(r_a && r_rd && r_oe));
    // R6 / R7: at most one loser
    a_r7_single_loser: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_busy_out && r_busy_out));
    // R8: busy only follows a leader-mode clash
    a_r8_l_busy_src: assert property (@(posedge clk) disable iff (!rst_n)
        l_busy_out |-> $past(clash));
    a_r8_r_busy_src: assert property (@(posedge clk) disable iff (!rst_n)
        r_busy_out |-> $past(clash));
    // R11: follower never drives busy, veto blocks writes
    a_r11_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $past(slave_mode) |-> (!l_busy_out && !r_busy_out));
    a_r11_l_veto: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_mode && l_busy_in) |-> !l_wr_en);
    a_r11_r_veto: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_mode && r_busy_in) |-> !r_wr_en);
    // R3: no write without an active port
    a_r3_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_a |-> !l_wr_en) and (!r_a |-> !r_wr_en));
endmodule

bind shared_ram_arb shared_ram_arb_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
    .l_sel(l_sel), .l_rd(l_rd), .l_oe(l_oe), .l_ub(l_ub), .l_lb(l_lb), .l_busy_in(l_busy_in),
    .r_sel(r_sel), .r_rd(r_rd), .r_oe(r_oe), .r_ub(r_ub), .r_lb(r_lb), .r_busy_in(r_busy_in),
    .l_addr(l_addr), .r_addr(r_addr),
    .l_rvalid(l_rvalid), .r_rvalid(r_rvalid),
    .l_busy_out(l_busy_out), .r_busy_out(r_busy_out),
    .l_wr_en(l_wr_en), .r_wr_en(r_wr_en)
);

// File: tb/test_shared_ram_arb.sv
module test_shared_ram_arb;
    localparam int AW = 10;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n, slave_mode;
    logic l_sel, l_rd, l_oe, l_ub, l_lb, l_busy_in;
    logic r_sel, r_rd, r_oe, r_ub, r_lb, r_busy_in;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
    logic l_rvalid, r_rvalid, l_busy_out, r_busy_out;

    logic [DW-1:0] ref_mem [1 << AW];
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    shared_ram_arb #(.ADDR_W(AW), .DATA_W(DW)) i_shared_ram_arb (.*);

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_l(input logic s, rd, oe, ub, lb, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input logic bi);
        l_sel = s; l_rd = rd; l_oe = oe; l_ub = ub; l_lb = lb;
        l_addr = a; l_wdata = d; l_busy_in = bi;
    endtask

    task automatic drive_r(input logic s, rd, oe, ub, lb, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input logic bi);
        r_sel = s; r_rd = rd; r_oe = oe; r_ub = ub; r_lb = lb;
        r_addr = a; r_wdata = d; r_busy_in = bi;
    endtask

    task automatic idle_all();
        drive_l(0, 1, 0, 0, 0, '0, '0, 0);
        drive_r(0, 1, 0, 0, 0, '0, '0, 0);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic prewrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
        idle_all();
        drive_l(1, 0, 0, 1, 1, a, d, 0);
        step();
        ref_mem[a] = d;
        idle_all();
        step();
    endtask

    task automatic read_l(input logic [AW-1:0] a, input string tag);
        idle_all();
        drive_l(1, 1, 1, 1, 1, a, '0, 0);
        step();
        chk({tag, " valid"}, {15'd0, l_rvalid}, 16'd1);
        chk(tag, l_rdata, ref_mem[a]);
        idle_all();
        step();
    endtask

    task automatic t_reset();
        rst_n = 0; slave_mode = 0; idle_all();
        repeat (3) step();
        rst_n = 1;
        step();
        chk("R1 l_rvalid", {15'd0, l_rvalid}, 16'd0);
        chk("R1 r_rvalid", {15'd0, r_rvalid}, 16'd0);
        chk("R1 l_busy", {15'd0, l_busy_out}, 16'd0);
        chk("R1 r_busy", {15'd0, r_busy_out}, 16'd0);
    endtask

    task automatic t_independent();
        drive_l(1, 0, 0, 1, 1, 10'h010, 16'h1234, 0);
        drive_r(1, 0, 0, 1, 1, 10'h020, 16'hABCD, 0);
        step();
        ref_mem[10'h010] = 16'h1234; ref_mem[10'h020] = 16'hABCD;
        drive_l(1, 1, 1, 1, 1, 10'h020, '0, 0);
        drive_r(1, 1, 1, 1, 1, 10'h010, '0, 0);
        step();
        chk("R2 left sees right write", l_rdata, 16'hABCD);
        chk("R2 right sees left write", r_rdata, 16'h1234);
        chk("R5 r_rvalid on read", {15'd0, r_rvalid}, 16'd1);
        idle_all();
        step();
    endtask

    task automatic t_lanes();
        prewrite(10'h030, 16'h0000);
        drive_l(1, 0, 0, 1, 0, 10'h030, 16'hA5C3, 0);  // upper lane only
        step();
        drive_l(1, 0, 0, 0, 1, 10'h030, 16'h1F7E, 0);  // lower lane only
        step();
        ref_mem[10'h030] = 16'hA57E;
        drive_l(1, 1, 1, 1, 0, 10'h030, '0, 0);
        step();
        chk("R4 upper-lane read", l_rdata, 16'hA500);
        drive_l(1, 1, 1, 0, 1, 10'h030, '0, 0);
        step();
        chk("R4 lower-lane read", l_rdata, 16'h007E);
        idle_all();
        step();
        read_l(10'h030, "R4 both lanes");
    endtask

    task automatic t_no_access();
        drive_l(0, 0, 0, 1, 1, 10'h030, 16'h0000, 0);   // deselected write
        drive_r(1, 0, 0, 0, 0, 10'h030, 16'hFFFF, 0);   // no lanes
        step();
        drive_l(0, 1, 1, 1, 1, 10'h030, '0, 0);
        drive_r(1, 1, 1, 0, 0, 10'h030, '0, 0);
        step();
        chk("R3 deselected read valid", {15'd0, l_rvalid}, 16'd0);
        chk("R3 no-lane read valid", {15'd0, r_rvalid}, 16'd0);
        idle_all();
        step();
        read_l(10'h030, "R3 word unchanged");
    endtask

    task automatic t_oe();
        drive_l(1, 1, 0, 1, 1, 10'h010, '0, 0);
        step();
        chk("R5 oe low valid", {15'd0, l_rvalid}, 16'd0);
        chk("R5 oe low data", l_rdata, 16'h0000);
        idle_all();
        step();
    endtask

    task automatic t_read_during_write();
        prewrite(10'h040, 16'h1111);
        slave_mode = 1;
        drive_l(1, 1, 1, 1, 1, 10'h040, '0, 0);
        drive_r(1, 0, 0, 1, 1, 10'h040, 16'h2222, 0);
        step();
        ref_mem[10'h040] = 16'h2222;
        chk("R12 read returns old word", l_rdata, 16'h1111);
        idle_all();
        step();
        slave_mode = 0;
        read_l(10'h040, "R12 new word after");
    endtask

    task automatic t_earlier_wins();
        prewrite(10'h050, 16'h5555);
        drive_r(1, 1, 1, 1, 1, 10'h050, '0, 0);          // right arrives first
        step();
        drive_l(1, 0, 0, 1, 1, 10'h050, 16'h9999, 0);    // left arrives later, writes
        step();
        chk("R6 newcomer busy", {15'd0, l_busy_out}, 16'd1);
        chk("R6 first port not busy", {15'd0, r_busy_out}, 16'd0);
        chk("R6 first port read", r_rdata, 16'h5555);
        step();
        chk("R8 busy held", {15'd0, l_busy_out}, 16'd1);
        drive_l(0, 1, 0, 0, 0, '0, '0, 0);
        step();
        chk("R8 busy clears on deselect", {15'd0, l_busy_out}, 16'd0);
        idle_all();
        step();
        read_l(10'h050, "R9 blocked write left word");
    endtask

    task automatic t_tie();
        drive_l(1, 0, 0, 1, 1, 10'h060, 16'h7777, 0);
        drive_r(1, 0, 0, 1, 1, 10'h060, 16'h8888, 0);
        step();
        ref_mem[10'h060] = 16'h7777;
        chk("R7 right busy on tie", {15'd0, r_busy_out}, 16'd1);
        chk("R7 left not busy on tie", {15'd0, l_busy_out}, 16'd0);
        step();
        chk("R8 winner held", {15'd0, r_busy_out}, 16'd1);
        drive_r(1, 0, 0, 1, 1, 10'h061, 16'h8888, 0);
        step();
        ref_mem[10'h061] = 16'h8888;
        chk("R8 busy clears on address change", {15'd0, r_busy_out}, 16'd0);
        idle_all();
        step();
        read_l(10'h060, "R9 winner write kept");
        read_l(10'h061, "R8 loser free after clash");
    endtask

    task automatic t_master_ignores_veto();
        drive_l(1, 0, 0, 1, 1, 10'h070, 16'h0707, 1);
        step();
        ref_mem[10'h070] = 16'h0707;
        idle_all();
        step();
        read_l(10'h070, "R10 veto ignored in leader mode");
    endtask

    task automatic t_slave();
        prewrite(10'h080, 16'h0101);
        slave_mode = 1;
        drive_l(1, 0, 0, 1, 1, 10'h080, 16'h0808, 1);  // vetoed
        drive_r(1, 0, 0, 1, 1, 10'h080, 16'h0909, 0);  // allowed
        step();
        ref_mem[10'h080] = 16'h0909;
        chk("R11 left busy low", {15'd0, l_busy_out}, 16'd0);
        chk("R11 right busy low", {15'd0, r_busy_out}, 16'd0);
        drive_l(1, 1, 1, 1, 1, 10'h080, '0, 1);
        drive_r(0, 1, 0, 0, 0, '0, '0, 0);
        step();
        chk("R11 vetoed read still valid", {15'd0, l_rvalid}, 16'd1);
        chk("R11 veto blocked write", l_rdata, 16'h0909);
        idle_all();
        step();
        slave_mode = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_independent();
        t_lanes();
        t_no_access();
        t_oe();
        t_read_during_write();
        t_earlier_wins();
        t_tie();
        t_master_ignores_veto();
        t_slave();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule